// File: doc/BRIEF.md
# Converter Output Test Pattern Generator

This block sits on the output datapath of a multi-channel data converter, just before the serial output link. When its 4-bit pattern select is zero, each conversion result goes through unchanged. Any nonzero select replaces the samples with a synthetic word stream, so the downstream receiver can check alignment, bit ordering and link integrity without an analog input. The streams are fixed codes, toggles, a checkerboard, two pseudo-noise generators with their own reseed strobes, a walking one, a mixed-frequency word and user-programmed words with four sequencing options.

One word leaves the block on every clock through a single output register, so there is one cycle of latency. Sequenced patterns restart on "entry". Entry is the first cycle in which the select differs from its value in the previous cycle; right after reset, the previous select counts as zero. In user mode, a change of the user sequencing field is also an entry. The word index k of an entry cycle is 0, and it rises by one on each later word of the same pattern.

Top module: `adc_test_pattern`

## Requirements
- R1: While reset is low, the output word is 0 and the valid flag is 0. After reset, the valid flag is 1 on every word. With select 0, the output equals the sample input from the previous clock.
- R2: Select 1 gives midscale (only bit 13 set, 0x2000). Select 2 gives all ones (0x3FFF). Select 3 gives all zeros.
- R3: Select 4 gives 0x2AAA for even k and 0x1555 for odd k. Select 7 gives 0x3FFF for even k and 0x0000 for odd k.
- R4: Select 5 outputs bits 13:0 of a 23-bit register whose polynomial is x^23+x^18+1. On each clock the register shifts toward its MSB and takes bit22 XOR bit17 into bit 0. It steps on every clock in every mode. Reset, or its own reseed strobe, loads all ones on the next clock.
- R5: Select 6 outputs a 9-bit register whose polynomial is x^9+x^5+1. It steps in the same way, taking bit8 XOR bit4 into bit 0. Output bit i is register bit (i mod 9). It has its own reseed strobe, which behaves as in R4.
- R6: Select 8 with user field 0 repeats word A. With user field 1, it gives A for even k and B for odd k.
- R7: Select 8 with user field 2 gives A at k=0 and 0 afterwards. With user field 3, it gives A at k=0, B at k=1 and 0 afterwards.
- R8: The user field has no effect on the output unless the select is 8.
- R9: Select 9 toggles bit 0 only: 1 for even k and 0 for odd k, with all other bits 0.
- R10: Select 10 gives a constant word with the low 7 bits set (0x007F).
- R11: Select 11 gives a single set bit at position (k mod 14).
- R12: Select 12 sets output bit i to bit (i mod 4) of (k mod 16).
- R13: Selects 13, 14 and 15 give 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_i | input | 14 | Normal conversion result |
| pat_sel_i | input | 4 | Pattern select, 0 = normal data |
| user_seq_i | input | 2 | User word sequencing, used only with select 8 |
| pn_long_clr_i | input | 1 | Reseed strobe for the 23-stage generator |
| pn_short_clr_i | input | 1 | Reseed strobe for the 9-stage generator |
| user_a_i | input | 14 | First user word |
| user_b_i | input | 14 | Second user word |
| dout_o | output | 14 | Output word |
| dvalid_o | output | 1 | Output word valid |

## Verification
A reseed strobe can arrive in the same cycle that a pseudo-noise word is being emitted. The bench forces this in two ways: it pulses both strobes in the middle of a run, and it asserts one strobe in the very cycle that the PN select is entered. The word registered in that cycle must still come from the register state before the reseed, and the next word must be the all-ones seed. The second collision pairs a change of the user field with the sequencing counters. In select 8 this restarts the once-only sequences. In every other select the field is varied on every clock, and the output must keep its phase.

// File: rtl/adc_tpg_pkg.sv
package adc_tpg_pkg;
  typedef enum logic [3:0] {
    SEL_PASS = 4'd0,  SEL_MID  = 4'd1,  SEL_PFS  = 4'd2,  SEL_NFS  = 4'd3,
    SEL_CHK  = 4'd4,  SEL_PNL  = 4'd5,  SEL_PNS  = 4'd6,  SEL_WTOG = 4'd7,
    SEL_USER = 4'd8,  SEL_BTOG = 4'd9,  SEL_SYNC = 4'd10, SEL_WALK = 4'd11,
    SEL_MIX  = 4'd12
  } pat_sel_e;

  typedef enum logic [1:0] {
    USQ_REPEAT = 2'd0, USQ_ALT = 2'd1, USQ_ONCE = 2'd2, USQ_ALT_ONCE = 2'd3
  } user_seq_e;
endpackage

// File: rtl/adc_tpg_lfsr.sv
module adc_tpg_lfsr #(
  parameter int LEN = 23,
  parameter int TAP = 18,
  parameter int W   = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  output logic [W-1:0] word_o
);
  logic [LEN-1:0] st_q;
  logic           fb_bit;

  assign fb_bit = st_q[LEN-1] ^ st_q[TAP-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= '1;
    else if (clr_i) st_q <= '1;
    else            st_q <= {st_q[LEN-2:0], fb_bit};
  end

  for (genvar i = 0; i < W; i++) begin : g_map
    assign word_o[i] = st_q[i % LEN];
  end

  // R4 / R5: a reseed strobe loads the all-ones seed on the following clock
  assert_reseed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (st_q == '1));
  // R4 / R5: without a strobe the register shifts by one place
  assert_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (st_q[LEN-1:1] == $past(st_q[LEN-2:0])));
endmodule

// File: rtl/adc_tpg_seq.sv
module adc_tpg_seq #(
  parameter int W = 14,
  localparam int PW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart_i,
  output logic [3:0]    k_o,
  output logic [PW-1:0] pos_o,
  output logic [1:0]    once_o
);
  logic [3:0]    k_q;
  logic [PW-1:0] pos_q;
  logic [1:0]    once_q;

  assign k_o    = restart_i ? '0 : k_q;
  assign pos_o  = restart_i ? '0 : pos_q;
  assign once_o = restart_i ? '0 : once_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_q    <= '0;
      pos_q  <= '0;
      once_q <= '0;
    end else begin
      k_q    <= k_o + 4'd1;
      pos_q  <= (pos_o == PW'(W - 1)) ? '0 : pos_o + PW'(1);
      once_q <= (once_o == 2'd2) ? 2'd2 : once_o + 2'd1;
    end
  end

  // R7: the once-only counter saturates at two words
  assert_once_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    once_q != 2'd3);
  // R11: the walking position stays inside the word
  assert_walk_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q < PW'(W));
endmodule

// File: rtl/adc_test_pattern.sv
module adc_test_pattern
  import adc_tpg_pkg::*;
#(
  parameter int W = 14,
  localparam int PW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] smp_i,
  input  logic [3:0]   pat_sel_i,
  input  logic [1:0]   user_seq_i,
  input  logic         pn_long_clr_i,
  input  logic         pn_short_clr_i,
  input  logic [W-1:0] user_a_i,
  input  logic [W-1:0] user_b_i,
  output logic [W-1:0] dout_o,
  output logic         dvalid_o
);
  function automatic logic [W-1:0] checker_word(input logic ph);
    for (int i = 0; i < W; i++) checker_word[i] = (i % 2 == 1) ^ ph;
  endfunction

  function automatic logic [W-1:0] mixed_word(input logic [3:0] k);
    for (int i = 0; i < W; i++) mixed_word[i] = k[i % 4];
  endfunction

  function automatic logic [W-1:0] user_word(input logic [1:0] seq, input logic [3:0] k,
                                             input logic [1:0] n, input logic [W-1:0] a,
                                             input logic [W-1:0] b);
    case (user_seq_e'(seq))
      USQ_REPEAT:   user_word = a;
      USQ_ALT:      user_word = k[0] ? b : a;
      USQ_ONCE:     user_word = (n == 2'd0) ? a : '0;
      default:      user_word = (n == 2'd0) ? a : (n == 2'd1) ? b : '0;
    endcase
  endfunction

  logic [3:0]    sel_q;
  logic [1:0]    useq_q;
  logic          restart;
  logic [3:0]    k;
  logic [PW-1:0] pos;
  logic [1:0]    once_n;
  logic [W-1:0]  pn_long_w, pn_short_w, pat_w;

  assign restart = (pat_sel_i != sel_q) ||
                   ((pat_sel_i == SEL_USER) && (user_seq_i != useq_q));

  adc_tpg_seq #(.W(W)) seq_i (
    .clk(clk), .rst_n(rst_n), .restart_i(restart),
    .k_o(k), .pos_o(pos), .once_o(once_n)
  );

  adc_tpg_lfsr #(.LEN(23), .TAP(18), .W(W)) pn_long_i (
    .clk(clk), .rst_n(rst_n), .clr_i(pn_long_clr_i), .word_o(pn_long_w)
  );

  adc_tpg_lfsr #(.LEN(9), .TAP(5), .W(W)) pn_short_i (
    .clk(clk), .rst_n(rst_n), .clr_i(pn_short_clr_i), .word_o(pn_short_w)
  );

  always_comb begin
    case (pat_sel_i)
      SEL_PASS: pat_w = smp_i;
      SEL_MID:  pat_w = W'(1) << (W - 1);
      SEL_PFS:  pat_w = '1;
      SEL_NFS:  pat_w = '0;
      SEL_CHK:  pat_w = checker_word(k[0]);
      SEL_PNL:  pat_w = pn_long_w;
      SEL_PNS:  pat_w = pn_short_w;
      SEL_WTOG: pat_w = k[0] ? '0 : '1;
      SEL_USER: pat_w = user_word(user_seq_i, k, once_n, user_a_i, user_b_i);
      SEL_BTOG: pat_w = W'(!k[0]);
      SEL_SYNC: pat_w = W'({(W / 2){1'b1}});
      SEL_WALK: pat_w = W'(1) << pos;
      SEL_MIX:  pat_w = mixed_word(k);
      default:  pat_w = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '0;
      useq_q   <= '0;
      dout_o   <= '0;
      dvalid_o <= 1'b0;
    end else begin
      sel_q    <= pat_sel_i;
      useq_q   <= user_seq_i;
      dout_o   <= pat_w;
      dvalid_o <= 1'b1;
    end
  end

  assert_reset_R1: assert property (@(posedge clk) !rst_n |-> (dout_o == '0 && !dvalid_o));
  assert_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (dvalid_o && $past(pat_sel_i) == 4'd0) |-> dout_o == $past(smp_i));
  assert_full_scale_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dvalid_o && $past(pat_sel_i) == 4'd2) |-> dout_o == '1);
  assert_word_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dvalid_o && $past(pat_sel_i) == 4'd7) |-> (dout_o == '1 || dout_o == '0));
  assert_one_hot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dvalid_o && $past(pat_sel_i) == 4'd11) |-> $countones(dout_o) == 1);
  assert_spare_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (dvalid_o && $past(pat_sel_i) >= 4'd13) |-> dout_o == '0);
endmodule

// File: tb/adc_test_pattern_tb_top.sv
module adc_test_pattern_tb_top;
  localparam int W = 14;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] smp = '0, ua = '0, ub = '0;
  logic [3:0]   sel = '0;
  logic [1:0]   useq = '0;
  logic         clr_l = 1'b0, clr_s = 1'b0;
  logic [W-1:0] dout;
  logic         dvalid;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  int m_sel_q = 0, m_useq_q = 0, m_k = 0, m_pos = 0, m_once = 0;
  logic [22:0] p23 = '1;
  logic [8:0]  p9 = '1;

  always #10 clk = ~clk;

  adc_test_pattern dut_i (
    .clk(clk), .rst_n(rst_n), .smp_i(smp), .pat_sel_i(sel), .user_seq_i(useq),
    .pn_long_clr_i(clr_l), .pn_short_clr_i(clr_s), .user_a_i(ua), .user_b_i(ub),
    .dout_o(dout), .dvalid_o(dvalid)
  );

  function automatic string req_name(int s, int u);
    string r;
    case (s)
      0: r = "R1";  1, 2, 3: r = "R2";  4, 7: r = "R3";  5: r = "R4";  6: r = "R5";
      8: r = (u < 2) ? "R6" : "R7";
      9: r = "R9";  10: r = "R10";  11: r = "R11";  12: r = "R12";
      default: r = "R13";
    endcase
    if (s != 8 && u != 0) r = {r, "+R8"};
    return r;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%04h expected 0x%04h (sel %0d useq %0d)", req, act, exp, sel, useq);
    end
  endtask

  // One word: drive at the falling edge, predict, sample 1 ns after the rising edge.
  task automatic step(int s, int u, bit cl, bit cs);
    logic [W-1:0] exp;
    int k, pos, once;
    bit restart;
    @(negedge clk);
    sel = 4'(s); useq = 2'(u); clr_l = cl; clr_s = cs;
    smp = W'($urandom); ua = W'($urandom); ub = W'($urandom);
    restart = (s != m_sel_q) || (s == 8 && u != m_useq_q);
    k = restart ? 0 : m_k;
    pos = restart ? 0 : m_pos;
    once = restart ? 0 : m_once;
    case (s)
      0: exp = smp;
      1: exp = 14'h2000;
      2: exp = 14'h3FFF;
      3: exp = 14'h0000;
      4: exp = (k % 2 == 0) ? 14'h2AAA : 14'h1555;
      5: exp = p23[13:0];
      6: for (int i = 0; i < W; i++) exp[i] = p9[i % 9];
      7: exp = (k % 2 == 0) ? 14'h3FFF : 14'h0000;
      8: case (u)
           0: exp = ua;
           1: exp = (k % 2 == 0) ? ua : ub;
           2: exp = (once == 0) ? ua : '0;
           default: exp = (once == 0) ? ua : (once == 1) ? ub : '0;
         endcase
      9: exp = (k % 2 == 0) ? 14'h0001 : 14'h0000;
      10: exp = 14'h007F;
      11: exp = 14'd1 << (k % 14);
      12: for (int i = 0; i < W; i++) exp[i] = ((k % 16) >> (i % 4)) & 1;
      default: exp = '0;
    endcase
    @(posedge clk);
    #1;
    check(req_name(s, u), dout, exp);
    if (dvalid !== 1'b1) check("R1 valid", W'(dvalid), W'(1));
    m_k = k + 1; m_pos = (pos + 1) % 14; m_once = (once < 2) ? once + 1 : 2;
    p23 = cl ? '1 : {p23[21:0], p23[22] ^ p23[17]};
    p9  = cs ? '1 : {p9[7:0], p9[8] ^ p9[4]};
    m_sel_q = s; m_useq_q = u;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset word", dout, '0);
    check("R1 reset valid", W'(dvalid), '0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int s = 0; s < 16; s++) begin
      if (s == 8) begin
        for (int u = 0; u < 4; u++)
          for (int c = 0; c < 20; c++) step(8, u, 0, 0);
        step(8, 3, 0, 0);
        for (int c = 0; c < 4; c++) step(8, c % 4, 0, 0);   // R7 restart on field change
      end else begin
        for (int c = 0; c < 40; c++)
          step(s, c % 4, (c == 11) || (c == 30), (c == 7) || (c == 30));
      end
    end
    // R4 / R5: reseed strobe in the very cycle the PN select is entered
    step(0, 0, 0, 0);
    step(5, 0, 1, 1);
    for (int c = 0; c < 10; c++) step(5, 0, 0, 0);
    step(6, 0, 1, 1);
    for (int c = 0; c < 12; c++) step(6, 0, 0, 0);
    finished = 1;
    report();
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end
endmodule